// File: doc/BRIEF.md
# Hard-Fault Error Counter Bank

This block attributes result-checker mismatches to the deconfigurable units a retiring instruction touched, and switches off units that keep failing. Every unit (an ALU, a reorder-buffer entry or a reservation-station entry) owns a saturating error counter. Each retiring instruction arrives with a usage vector that has one bit per unit. When the retiring instruction is also flagged as wrong by the downstream checker, the counter of every marked unit is charged one error.

A unit whose count rises above its own programmable limit is flagged as faulty and removed from service for good. The limits are per unit, so that heavily used units can tolerate more errors before they are blamed. The disable mask is consumed by scheduling logic elsewhere, and that logic must never be left without at least one working unit of a kind. A removal that would empty a kind is therefore refused, and a sticky fatal indication is raised instead.

Top module: `hf_diag_bank`

## Requirements
- R1: On a cycle with retire_valid and chk_error both high, the counter of every unit whose usage bit is set grows by one, and no other counter changes.
- R2: chk_error without retire_valid, and retire_valid without chk_error, leave every counter, the disable mask and the fault flags unchanged.
- R3: Counters are CNT_W bits wide (6 by default) and stop at 63 instead of wrapping.
- R4: A limit is written by asserting thr_we with the unit number on thr_idx and the limit on thr_data. An index at or above the unit count is ignored. A write takes effect from the following cycle.
- R5: On an error event, a used unit whose updated count is strictly greater than its limit is deconfigured. Its disable_mask bit rises on the clock edge that updates the counter, and it never falls again until reset.
- R6: fault_flag of a unit is set, and stays set, on the edge where that unit's count exceeds its limit, whether or not the removal is allowed. A set disable_mask bit always has its fault_flag set.
- R7: If granting the removals of one kind in a cycle would leave that kind with no enabled unit, none of that kind's removals is granted in that cycle, and fatal is set and held.
- R8: A synchronous active-high rst clears all counters, the disable mask, the fault flags and fatal, and loads every limit with DEF_THR (3 by default).
- R9: Unit numbering, shared by usage, thr_idx, disable_mask and fault_flag, places the ALUs at bits 0 to 3, the reorder-buffer entries at bits 4 to 11, and the reservation-station entries at bits 12 to 18.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_valid | input | 1 | An instruction retires this cycle |
| chk_error | input | 1 | Checker reports a wrong result for the retiring instruction |
| usage | input | 19 | Units used by the retiring instruction |
| thr_we | input | 1 | Limit write strobe |
| thr_idx | input | 5 | Unit number for the limit write |
| thr_data | input | 6 | New limit |
| disable_mask | output | 19 | Units removed from service |
| fault_flag | output | 19 | Units whose count has exceeded their limit |
| fatal | output | 1 | A kind's last enabled unit was due for removal |

## Verification
The bench drives an error into every unit one at a time across graded limits, which shows both a misrouted counter and an off-by-one comparison (at or above the limit instead of strictly above it). It drives the ALU group until its last survivor is due for removal. A design without the guard would disable that unit, and a design with a wrong guard would stay silent on fatal.

A counter that wraps is exposed by overrunning it and then lowering its limit: a saturated count still exceeds the new limit, while a wrapped count does not. Strobes that must be ignored are shown to be ignored through a later real error, which lands exactly on the limit and must not trip the unit. A long pseudo-random stretch of multi-unit usage patterns with mixed strobes then covers simultaneous removals in several kinds.

// File: rtl/hf_diag_bank.sv
`timescale 1ns/1ps
module hf_diag_bank #(
  parameter int N_ALU   = 4,
  parameter int N_ROB   = 8,
  parameter int N_RS    = 7,
  parameter int CNT_W   = 6,
  parameter int DEF_THR = 3,
  localparam int N      = N_ALU + N_ROB + N_RS,
  localparam int IDX_W  = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             retire_valid,
  input  logic             chk_error,
  input  logic [N-1:0]     usage,
  input  logic             thr_we,
  input  logic [IDX_W-1:0] thr_idx,
  input  logic [CNT_W-1:0] thr_data,
  output logic [N-1:0]     disable_mask,
  output logic [N-1:0]     fault_flag,
  output logic             fatal
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [N-1:0] M_ALU = {{(N-N_ALU){1'b0}}, {N_ALU{1'b1}}};
  localparam logic [N-1:0] M_ROB = {{(N-N_ROB){1'b0}}, {N_ROB{1'b1}}} << N_ALU;
  localparam logic [N-1:0] M_RS  = ~(M_ALU | M_ROB);
  localparam logic [2:0][N-1:0] GRP = {M_RS, M_ROB, M_ALU};

  logic [N-1:0][CNT_W-1:0] cnt_q, thr_q, cnt_inc;
  logic [N-1:0] over, req, blk_mask, grant;
  logic [2:0]   grp_block;
  logic         hit;

  assign hit = retire_valid & chk_error;

  for (genvar i = 0; i < N; i++) begin : g_unit
    assign cnt_inc[i] = (cnt_q[i] == CMAX) ? CMAX : cnt_q[i] + 1'b1;
    assign over[i]    = hit & usage[i] & (cnt_inc[i] > thr_q[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q[i] <= '0;
        thr_q[i] <= CNT_W'(DEF_THR);
      end else begin
        if (hit && usage[i]) cnt_q[i] <= cnt_inc[i];
        if (thr_we && thr_idx == IDX_W'(i)) thr_q[i] <= thr_data;
      end
    end
  end

  assign req = over & ~disable_mask;

  for (genvar g = 0; g < 3; g++) begin : g_grp
    assign grp_block[g] = (|(~disable_mask & GRP[g])) & ~(|(~disable_mask & ~req & GRP[g]));
  end

  always_comb begin
    blk_mask = '0;
    for (int g = 0; g < 3; g++)
      if (grp_block[g]) blk_mask = blk_mask | GRP[g];
  end

  assign grant = req & ~blk_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      disable_mask <= '0;
      fault_flag   <= '0;
      fatal        <= 1'b0;
    end else begin
      disable_mask <= disable_mask | grant;
      fault_flag   <= fault_flag | over;
      fatal        <= fatal | (|grp_block);
    end
  end
endmodule

module hf_diag_bank_chk #(
  parameter int N_ALU = 4,
  parameter int N_ROB = 8,
  parameter int N_RS  = 7,
  parameter int CNT_W = 6,
  localparam int N    = N_ALU + N_ROB + N_RS
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    retire_valid,
  input logic                    chk_error,
  input logic [N-1:0]            disable_mask,
  input logic [N-1:0]            fault_flag,
  input logic                    fatal,
  input logic [N-1:0][CNT_W-1:0] cnt
);
  localparam logic [N-1:0] M_ALU = {{(N-N_ALU){1'b0}}, {N_ALU{1'b1}}};
  localparam logic [N-1:0] M_ROB = {{(N-N_ROB){1'b0}}, {N_ROB{1'b1}}} << N_ALU;
  localparam logic [N-1:0] M_RS  = ~(M_ALU | M_ROB);
  localparam logic [2:0][N-1:0] GRP = {M_RS, M_ROB, M_ALU};

  assert_mask_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (($past(disable_mask) & ~disable_mask) == '0));

  assert_mask_has_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (disable_mask & ~fault_flag) == '0);

  assert_fatal_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    fatal |=> fatal);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!rst && !(retire_valid && chk_error)) |=>
      ($stable(disable_mask) && $stable(fault_flag) && $stable(cnt)));

  for (genvar g = 0; g < 3; g++) begin : g_alive
    assert_group_alive_R7: assert property (@(posedge clk) disable iff (rst)
      |(~disable_mask & GRP[g]));
  end

  for (genvar i = 0; i < N; i++) begin : g_sat
    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (cnt[i] >= $past(cnt[i])));
  end
endmodule

bind hf_diag_bank hf_diag_bank_chk #(
  .N_ALU(N_ALU), .N_ROB(N_ROB), .N_RS(N_RS), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst(rst), .retire_valid(retire_valid), .chk_error(chk_error),
  .disable_mask(disable_mask), .fault_flag(fault_flag), .fatal(fatal), .cnt(cnt_q)
);

// File: tb/hf_diag_bank_tb_top.sv
`timescale 1ns/1ps
module hf_diag_bank_tb_top;
  localparam int N_ALU = 4, N_ROB = 8, N_RS = 7, CNT_W = 6, DEF_THR = 3;
  localparam int N = N_ALU + N_ROB + N_RS;
  localparam int IDX_W = $clog2(N);
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst = 1'b1, retire_valid = 1'b0, chk_error = 1'b0, thr_we = 1'b0;
  logic [N-1:0] usage = '0;
  logic [IDX_W-1:0] thr_idx = '0;
  logic [CNT_W-1:0] thr_data = '0;
  logic [N-1:0] disable_mask, fault_flag;
  logic fatal;

  always #2.5 clk = ~clk;

  hf_diag_bank #(.N_ALU(N_ALU), .N_ROB(N_ROB), .N_RS(N_RS), .CNT_W(CNT_W), .DEF_THR(DEF_THR))
    dut_i (.clk(clk), .rst(rst), .retire_valid(retire_valid), .chk_error(chk_error),
           .usage(usage), .thr_we(thr_we), .thr_idx(thr_idx), .thr_data(thr_data),
           .disable_mask(disable_mask), .fault_flag(fault_flag), .fatal(fatal));

  int checks = 0, fails = 0;
  int mcnt [N];
  int mthr [N];
  logic [N-1:0] mmask, mflag;
  logic mfatal;
  logic [N-1:0] gm [3];
  logic [31:0] lfsr = 32'hACE1_1234;

  initial begin
    gm[0] = N'((1 << N_ALU) - 1);
    gm[1] = N'(((1 << N_ROB) - 1) << N_ALU);
    gm[2] = ~(gm[0] | gm[1]);
  end

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " disable_mask"}, disable_mask, mmask);
    chk({tag, " fault_flag"}, fault_flag, mflag);
    chk({tag, " fatal"}, N'(fatal), N'(mfatal));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; retire_valid = 1'b0; chk_error = 1'b0; thr_we = 1'b0; usage = '0;
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < N; i++) begin mcnt[i] = 0; mthr[i] = DEF_THR; end
    mmask = '0; mflag = '0; mfatal = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_thr(input int idx, input int val);
    @(negedge clk);
    thr_we = 1'b1; thr_idx = IDX_W'(idx); thr_data = CNT_W'(val);
    @(posedge clk);
    #1;
    if (idx < N) mthr[idx] = val;
    @(negedge clk);
    thr_we = 1'b0;
  endtask

  task automatic step(input logic rv, input logic er, input logic [N-1:0] u, input string tag);
    logic [N-1:0] over, req, blk;
    @(negedge clk);
    retire_valid = rv; chk_error = er; usage = u;
    @(posedge clk);
    #1;
    over = '0;
    if (rv && er)
      for (int i = 0; i < N; i++)
        if (u[i]) begin
          mcnt[i] = (mcnt[i] == CMAX) ? CMAX : mcnt[i] + 1;
          if (mcnt[i] > mthr[i]) over[i] = 1'b1;
        end
    req = over & ~mmask;
    blk = '0;
    for (int g = 0; g < 3; g++)
      if (|(~mmask & gm[g]) && !(|(~mmask & ~req & gm[g]))) begin
        blk = blk | gm[g];
        mfatal = 1'b1;
      end
    mmask = mmask | (req & ~blk);
    mflag = mflag | over;
    compare(tag);
    @(negedge clk);
    retire_valid = 1'b0; chk_error = 1'b0; usage = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    compare("R8 reset state");

    for (int i = 0; i < N; i++) set_thr(i, i % 4);
    set_thr(N + 3, 0);
    for (int i = 0; i < N; i++)
      for (int k = 0; k < 6; k++)
        step(1'b1, 1'b1, N'(1) << i, "R1 R4 R5 R6 R7 R9 single-unit sweep");

    step(1'b1, 1'b1, '1, "R7 all units error");
    do_reset();
    compare("R8 reset after sweep");

    set_thr(5, 1);
    for (int k = 0; k < 5; k++) step(1'b0, 1'b1, '1, "R2 error without retire");
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0, '1, "R2 retire without error");
    step(1'b1, 1'b1, N'(1) << 5, "R2 count at limit not tripped");
    step(1'b1, 1'b1, N'(1) << 5, "R4 count above limit trips");

    do_reset();
    set_thr(15, 63);
    for (int k = 0; k < 70; k++) step(1'b1, 1'b1, N'(1) << 15, "R3 overrun at max limit");
    set_thr(15, 62);
    step(1'b1, 1'b1, N'(1) << 15, "R3 saturated count exceeds lowered limit");

    do_reset();
    for (int i = 0; i < N; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      set_thr(i, 2 + int'(lfsr[3:0]));
    end
    for (int k = 0; k < 400; k++) begin
      for (int s = 0; s < 7; s++) lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[31] | lfsr[30], lfsr[29] | lfsr[28], lfsr[18:0] & lfsr[31:13],
           "R1 R2 R5 R6 R7 mixed patterns");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule